// File: doc/BRIEF.md
# Two-Wire Acquisition Command and Readout Slave

This block is the serial front end of an eight-channel, 12-bit multirange acquisition device. It oversamples the two bus lines with the system clock, cleans them through a synchronizer and glitch filter, and finds clock edges and START/STOP conditions. It answers to a 7-bit address made of a fixed upper nibble and three strap pins. It accepts control bytes on writes and serves the latest conversion result on reads. The data line is driven open-drain: the block only ever asks for the line to be pulled low.

A write carries one or more control bytes. Each control byte begins with a marker '1' bit, and zero bits ahead of the marker are skipped. The remaining bits select a channel, a span, unipolar or bipolar coding and a power-down mode. These fields go to a separate conversion controller as a decoded command. The controller also gets an acquisition-start strobe in the middle of the byte and a strobe when the write's STOP arrives. A read returns the 12-bit result left-justified across two bytes, with four zero bits as padding.

Top module: `acq_twi_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0101 followed by addr_i[2:0] (MSB first), by asserting sda_oe_o through the ninth SCL clock. The eighth bit is the direction: 0 = write, 1 = read.
- R2: After a non-matching address, sda_oe_o stays low and no command, acquisition or stop strobe is produced until the next START or STOP.
- R3: In a write, zero bits received before a '1' are skipped. The first '1' is the marker. The next seven bits, MSB first, are channel (3 bits), range (1), bipolar (1) and power-down (2). After the eighth bit, cmd_chan_o, cmd_range_o, cmd_bipolar_o and cmd_pd_o take those values and hold them, and cmd_valid_o pulses for one cycle.
- R4: Each control byte is acknowledged by asserting sda_oe_o through the ninth clock. After that, a further control byte may follow in the same write.
- R5: acq_start_o pulses exactly once per control byte. The pulse comes after the falling SCL edge of the byte's sixth bit (the bipolar bit) and before the seventh rising edge.
- R6: A read captures result_i when the address acknowledge ends. It returns result[11:4] in the first byte and {result[3:0], 4'b0000} in the second, MSB first. Each bit is presented after a falling SCL edge.
- R7: Master ACK and NACK after the first read byte are ignored: the second byte always follows. After the second byte, SDA is released, so further bytes read as all ones.
- R8: sda_oe_o changes only after a falling SCL edge or at a START or STOP. It never changes while SCL is high.
- R9: A START in any state returns the block to address reception. A repeated START in the middle of a control byte discards that byte. stop_o pulses once for a STOP that ends a write addressed to this block, and never for a read.
- R10: Reset releases SDA and clears the command outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_i | input | 3 | Address strap pins, low address bits |
| result_i | input | 12 | Latest conversion result |
| sda_oe_o | output | 1 | Pull SDA low when high |
| cmd_valid_o | output | 1 | One-cycle pulse: new control byte decoded |
| cmd_chan_o | output | 3 | Selected channel |
| cmd_range_o | output | 1 | Full-scale span select |
| cmd_bipolar_o | output | 1 | Bipolar coding select |
| cmd_pd_o | output | 2 | Power-down mode field |
| acq_start_o | output | 1 | One-cycle acquisition-start strobe |
| stop_o | output | 1 | One-cycle pulse: STOP ending a write to this block |

## Verification
Random control bytes test all field positions in the decoder, so a swapped or shifted field shows up as a wrong channel, span or mode. Random results with random ACK/NACK choices test the 12-bit split and the zero padding, and show that the master's acknowledge has no effect. Directed cases target the corner behaviour. Leading zeros before the marker and a repeated START cut into a half-sent control byte show marker qualification apart from plain bit counting. A wrong strap address and a third read byte show a selected bus from a released one. The sixth-fall timing check catches an acquisition strobe that is early or late by one bit.

// File: rtl/acq_twi_pkg.sv
package acq_twi_pkg;
  localparam int RES_W   = 12;
  localparam int PIN_W   = 3;
  localparam int CHAN_W  = 3;
  localparam int PD_W    = 2;
  localparam int PAD_W   = 4;
  localparam int TX_W    = RES_W + PAD_W;
  localparam int IDX_W   = $clog2(TX_W);
  localparam logic [3:0] ADDR_HI = 4'b0101;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_MARK, ST_CTRL, ST_CTRL_ACK,
    ST_RD, ST_RD_ACK, ST_DONE, ST_IGNORE
  } twi_state_e;
endpackage

// File: rtl/acq_twi_filter.sv
module acq_twi_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN) + 1;

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
          line_o <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/acq_twi_events.sv
module acq_twi_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/acq_twi_slave.sv
module acq_twi_slave
  import acq_twi_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  addr_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [CHAN_W-1:0] cmd_chan_o,
  output logic              cmd_range_o,
  output logic              cmd_bipolar_o,
  output logic [PD_W-1:0]   cmd_pd_o,
  output logic              acq_start_o,
  output logic              stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_l, filt_l;
  logic scl_f, sda_f;
  logic ev_rise, ev_fall, ev_start, ev_stop;

  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    acq_twi_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_l[g]),
      .line_o (filt_l[g])
    );
  end

  assign scl_f = filt_l[1];
  assign sda_f = filt_l[0];

  acq_twi_events u_ev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_f),
    .sda_i   (sda_f),
    .rise_o  (ev_rise),
    .fall_o  (ev_fall),
    .start_o (ev_start),
    .stop_o  (ev_stop)
  );

  twi_state_e       state_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sr_q;
  logic             rw_q;
  logic [RES_W-1:0] res_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [TX_W-1:0]  tx_w;
  logic             wr_sel;

  assign tx_w    = {res_q, {PAD_W{1'b0}}};
  assign idx_nxt = idx_q - 1'b1;
  assign wr_sel  = (state_q == ST_MARK) || (state_q == ST_CTRL) ||
                   (state_q == ST_CTRL_ACK) || ((state_q == ST_ADDR_ACK) && !rw_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      sr_q          <= '0;
      rw_q          <= 1'b0;
      res_q         <= '0;
      idx_q         <= '0;
      sda_oe_o      <= 1'b0;
      cmd_valid_o   <= 1'b0;
      cmd_chan_o    <= '0;
      cmd_range_o   <= 1'b0;
      cmd_bipolar_o <= 1'b0;
      cmd_pd_o      <= '0;
      acq_start_o   <= 1'b0;
      stop_o        <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      acq_start_o <= 1'b0;
      stop_o      <= 1'b0;
      if (ev_stop) begin
        stop_o   <= wr_sel;
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (ev_start) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (ev_rise) begin
              sr_q  <= {sr_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end
            if (ev_fall && cnt_q == 4'd8) begin
              if (sr_q[7:1] == {ADDR_HI, addr_i}) begin
                sda_oe_o <= 1'b1;
                rw_q     <= sr_q[0];
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: if (ev_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              res_q    <= result_i;
              idx_q    <= IDX_W'(TX_W - 1);
              sda_oe_o <= ~result_i[RES_W-1];
              state_q  <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_MARK;
            end
          end
          ST_MARK: if (ev_rise && sda_f) begin
            cnt_q   <= 4'd1;
            state_q <= ST_CTRL;
          end
          ST_CTRL: begin
            if (ev_rise) begin
              sr_q  <= {sr_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end
            if (ev_fall && cnt_q == 4'd6) acq_start_o <= 1'b1;
            if (ev_fall && cnt_q == 4'd8) begin
              sda_oe_o      <= 1'b1;
              cmd_valid_o   <= 1'b1;
              cmd_chan_o    <= sr_q[6:4];
              cmd_range_o   <= sr_q[3];
              cmd_bipolar_o <= sr_q[2];
              cmd_pd_o      <= sr_q[1:0];
              state_q       <= ST_CTRL_ACK;
            end
          end
          ST_CTRL_ACK: if (ev_fall) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_MARK;
          end
          ST_RD: if (ev_fall) begin
            if (cnt_q == 4'd7) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RD_ACK;
            end else begin
              sda_oe_o <= ~tx_w[idx_nxt];
              idx_q    <= idx_nxt;
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: if (ev_fall) begin
            // master acknowledge level is not consulted
            if (idx_q == IDX_W'(TX_W / 2)) begin
              sda_oe_o <= ~tx_w[idx_nxt];
              idx_q    <= idx_nxt;
              cnt_q    <= '0;
              state_q  <= ST_RD;
            end else begin
              state_q <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/acq_twi_slave_chk.sv
module acq_twi_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic ev_fall,
  input logic ev_start,
  input logic ev_stop,
  input logic acq_start_o,
  input logic cmd_valid_o,
  input logic stop_o
);
  // R8: drive changes only after a falling clock edge or a bus condition
  a_r8_oe_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(ev_fall | ev_start | ev_stop));

  a_r5_acq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_o |=> !acq_start_o);

  a_r5_acq_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_o |-> $past(ev_fall));

  a_r3_valid_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(ev_fall));

  a_r9_stop_follows_bus_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> $past(ev_stop));

  a_r9_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_start |=> !sda_oe_o);
endmodule

bind acq_twi_slave acq_twi_slave_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_oe_o    (sda_oe_o),
  .ev_fall     (ev_fall),
  .ev_start    (ev_start),
  .ev_stop     (ev_stop),
  .acq_start_o (acq_start_o),
  .cmd_valid_o (cmd_valid_o),
  .stop_o      (stop_o)
);

// File: tb/acq_twi_slave_bench.sv
`timescale 1ns/1ps
module acq_twi_slave_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] addr_pins = 3'd0;
  logic [11:0] result = 12'd0;
  logic sda_oe, cmd_valid, cmd_range, cmd_bip, acq_start, stop_p;
  logic [2:0] cmd_chan;
  logic [1:0] cmd_pd;
  logic sda_bus;

  int n_chk = 0, n_fail = 0;
  int falls = 0, valid_cnt = 0, acq_cnt = 0, acq_at = -1, stop_cnt = 0;
  int oe_hits = 0, oe_high_moves = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  acq_twi_slave u_acq_twi_slave (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_i(addr_pins), .result_i(result), .sda_oe_o(sda_oe),
    .cmd_valid_o(cmd_valid), .cmd_chan_o(cmd_chan), .cmd_range_o(cmd_range),
    .cmd_bipolar_o(cmd_bip), .cmd_pd_o(cmd_pd), .acq_start_o(acq_start),
    .stop_o(stop_p)
  );

  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always @(negedge clk) begin
    if (cmd_valid) valid_cnt++;
    if (acq_start) begin acq_cnt++; acq_at = falls; end
    if (stop_p) stop_cnt++;
    if (sda_oe) oe_hits++;
    if (rst_ni && scl_m && scl_prev && sda_oe != oe_prev) oe_high_moves++;
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(10); scl_m = 1'b1; tick(20);
    sda_m = 1'b0; tick(20); scl_m = 1'b0; falls++;
  endtask

  task automatic bus_stop();
    tick(10); sda_m = 1'b0; tick(10); scl_m = 1'b1; tick(20);
    sda_m = 1'b1; tick(20);
  endtask

  task automatic bit_xfer(input logic b, output logic seen, output logic oe_seen);
    tick(10); sda_m = b; tick(10); scl_m = 1'b1; tick(10);
    seen = sda_bus; oe_seen = sda_oe;
    tick(10); scl_m = 1'b0; falls++;
  endtask

  task automatic byte_out(input logic [7:0] v, output logic acked);
    logic s, o;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], s, o);
    bit_xfer(1'b1, s, o);
    acked = o & ~s;
  endtask

  task automatic byte_in(input logic mack, output logic [7:0] v);
    logic s, o;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s, o);
      v[i] = s;
    end
    bit_xfer(mack, s, o);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] pins, input logic rd);
    return {4'b0101, pins, rd};
  endfunction

  function automatic logic [7:0] hi_byte(input logic [11:0] r);
    return r[11:4];
  endfunction

  function automatic logic [7:0] lo_byte(input logic [11:0] r);
    return {r[3:0], 4'b0000};
  endfunction

  task automatic do_write(input logic [7:0] ctrl, input int zeros);
    logic ack, s, o;
    int v0, s0, f0;
    logic [7:0] c;
    c = ctrl | 8'h80;
    v0 = valid_cnt; s0 = stop_cnt;
    bus_start();
    byte_out(addr_byte(addr_pins, 1'b0), ack);
    check(ack, "R1 write address ack", ack, 1);
    for (int z = 0; z < zeros; z++) bit_xfer(1'b0, s, o);
    f0 = falls;
    byte_out(c, ack);
    check(ack, "R4 control byte ack", ack, 1);
    check(acq_at == f0 + 6, "R5 acquisition strobe after sixth fall", acq_at, f0 + 6);
    bus_stop();
    tick(10);
    check(valid_cnt == v0 + 1, "R3 one command pulse", valid_cnt - v0, 1);
    check({cmd_chan, cmd_range, cmd_bip, cmd_pd} == c[6:0], "R3 decoded fields",
          {cmd_chan, cmd_range, cmd_bip, cmd_pd}, c[6:0]);
    check(stop_cnt == s0 + 1, "R9 stop strobe after write", stop_cnt - s0, 1);
  endtask

  task automatic do_read(input logic [11:0] r, input logic mack0);
    logic ack;
    logic [7:0] b;
    int s0;
    s0 = stop_cnt;
    result = r;
    bus_start();
    byte_out(addr_byte(addr_pins, 1'b1), ack);
    check(ack, "R1 read address ack", ack, 1);
    byte_in(mack0, b);
    check(b == hi_byte(r), "R6 first read byte", b, hi_byte(r));
    byte_in(1'b0, b);
    check(b == lo_byte(r), "R7 second byte despite master ack/nack", b, lo_byte(r));
    byte_in(1'b1, b);
    check(b == 8'hFF, "R7 released after two bytes", b, 8'hFF);
    bus_stop();
    tick(10);
    check(stop_cnt == s0, "R9 no stop strobe after read", stop_cnt - s0, 0);
  endtask

  initial begin
    logic ack, s, o;
    int v0, a0, s0;
    void'($urandom(32'd1234));
    tick(5);
    check(sda_oe == 1'b0, "R10 reset releases SDA", sda_oe, 0);
    check({cmd_valid, cmd_chan, cmd_range, cmd_bip, cmd_pd, acq_start, stop_p} == '0,
          "R10 reset clears command", {cmd_chan, cmd_range, cmd_bip, cmd_pd}, 0);
    rst_ni = 1'b1;
    tick(10);

    // random mix of writes and reads
    for (int it = 0; it < 12; it++) begin
      addr_pins = 3'($urandom);
      do_write(8'($urandom), 0);
      do_read(12'($urandom), 1'($urandom));
    end

    // directed edges of result coding
    do_read(12'hFFF, 1'b1);
    do_read(12'h001, 1'b0);

    // zeros ahead of the marker are skipped
    addr_pins = 3'd5;
    do_write(8'h00, 3);
    do_write(8'h7F, 2);

    // non-matching address
    v0 = valid_cnt; a0 = acq_cnt; s0 = stop_cnt;
    tick(5); oe_hits = 0;
    bus_start();
    byte_out(addr_byte(3'd2, 1'b0), ack);
    byte_out(8'hA5, ack);
    bus_stop();
    tick(10);
    check(oe_hits == 0, "R2 SDA never pulled after foreign address", oe_hits, 0);
    check(valid_cnt == v0 && acq_cnt == a0 && stop_cnt == s0, "R2 no strobes",
          valid_cnt - v0 + acq_cnt - a0 + stop_cnt - s0, 0);

    // repeated START in the middle of a control byte
    v0 = valid_cnt; a0 = acq_cnt;
    bus_start();
    byte_out(addr_byte(addr_pins, 1'b0), ack);
    bit_xfer(1'b1, s, o); bit_xfer(1'b0, s, o); bit_xfer(1'b1, s, o); bit_xfer(1'b1, s, o);
    do_write(8'hC6, 0);
    check(valid_cnt == v0 + 1, "R9 partial byte discarded on repeated start", valid_cnt - v0, 1);
    check(acq_cnt == a0 + 1, "R9 single acquisition after restart", acq_cnt - a0, 1);

    // reset mid-run clears input register
    rst_ni = 1'b0; tick(3);
    check({cmd_chan, cmd_range, cmd_bip, cmd_pd} == '0 && !sda_oe, "R10 reset clears fields",
          {cmd_chan, cmd_range, cmd_bip, cmd_pd}, 0);
    rst_ni = 1'b1; tick(10);
    do_read(12'hA5C, 1'b1);

    check(oe_high_moves == 0, "R8 SDA drive stable while SCL high", oe_high_moves, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule